// File: doc/BRIEF.md
# Repeat-Driven Fractional Multiply-Accumulate Unit

This block is the arithmetic core for dot products inside a filter loop. It multiplies a coefficient by a sample, both signed fractions, keeps the result in a product register, and adds it to a wide accumulator. The coefficient comes from a program-side read port and the sample from a data-side read port. Both ports are read in the same cycle, so the block can do one multiply-accumulate per clock.

A small sequencer handles the repeated multiply-accumulate. When a repeat is launched, it loads a term counter and two operand pointers. On each busy cycle it performs one step and advances both pointers. It stops after `rpt_count + 1` steps. The product register holds each product for one step before it reaches the accumulator, so the accumulator always trails the multiplier by one term. A separate fold command therefore adds the last pending product. The full command set is:

- **Clear**: zeroes the accumulator and the product register.
- **Repeat**: launches the multiply-accumulate sequence.
- **Fold**: adds the pending product to the accumulator.
- **Store**: emits the upper half of the fractional result on a write strobe, saturated to the operand range.

Top module: `frac_mac_unit`

## Requirements
- R1: Operands are DW-bit two's complement fractions with the binary point just right of the sign bit. The accumulator LSB weighs 2^-(2*DW-1), so a folded product of operands `a` and `b` (as integers) adds exactly `2*a*b` to `acc_out`. This includes (-1)×(-1) = +1.0.
- R2: When idle, a clear command sets both the accumulator and the product register to zero on the next clock edge.
- R3: A repeat command taken while idle raises `busy` on the next edge. `busy` then stays high for exactly `rpt_count + 1` cycles, one step per cycle. A count of zero gives one step.
- R4: In the first busy cycle, `coef_addr` equals the captured `coef_base` and `samp_addr` equals the captured `samp_base`. Each later busy cycle advances both by one, modulo 2^AW. Operand data is consumed in the same cycle its address is presented.
- R5: Each step loads the product register with coefficient × sample and adds the previous product register value to the accumulator. When a repeat ends, the accumulator therefore holds every term except the last.
- R6: A fold command taken while idle adds the aligned product register value to the accumulator. The product register keeps its value, so a second fold adds it again.
- R7: A store command taken while idle pulses `st_valid` high for exactly one cycle, starting at the next edge. `st_data` then equals accumulator bits [2*DW-1:DW].
- R8: If accumulator bits [ACC_W-1:2*DW-1] are not all equal, the stored word is forced to the largest positive fraction (0 then all ones) when the accumulator is positive. It is forced to the most negative fraction (1 then all zeros) when the accumulator is negative.
- R9: The accumulator is 2*DW+GUARD bits wide, so it keeps exact sums that leave [-1, 1). A store after such a sum has come back into range gives the unsaturated result.
- R10: While `busy` is high, clear, repeat, fold and store commands have no effect. The accumulator result and the `st_valid` strobe are as if the commands never arrived.
- R11: When several commands arrive together while idle, only one takes effect. The priority order is clear, then repeat, then fold, then store.
- R12: During reset, `acc_out`, `busy`, `st_valid`, `st_data`, `coef_addr` and `samp_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_clear | input | 1 | Zero the accumulator and product register |
| cmd_repeat | input | 1 | Launch a repeated multiply-accumulate |
| cmd_fold | input | 1 | Add the pending product into the accumulator |
| cmd_store | input | 1 | Emit the saturated upper half of the result |
| rpt_count | input | CW | Number of steps minus one |
| coef_base | input | AW | First coefficient address |
| samp_base | input | AW | First sample address |
| coef_addr | output | AW | Coefficient read address |
| coef_data | input | DW | Coefficient read data, same cycle |
| samp_addr | output | AW | Sample read address |
| samp_data | input | DW | Sample read data, same cycle |
| busy | output | 1 | High while the repeat runs |
| acc_out | output | 2*DW+GUARD | Accumulator value |
| st_valid | output | 1 | One-cycle store strobe |
| st_data | output | DW | Stored fractional word |

## Verification
The bench builds the unit with DW=4, GUARD=4, AW=4 and CW=4. This gives a 12-bit accumulator and 16-entry coefficient and sample spaces. With these parameters, all 256 operand pairs can be swept one by one through a one-term repeat and double folds. That sweep reaches the exact products, the +1.0 corner, and both saturation limits. Multi-term runs with bases near the top of the address space exercise pointer wrap. Deliberate excursions of the sum beyond ±1 show the guard bits holding the exact value until it comes back into range.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CLEAR,
      OP_REPEAT,
      OP_FOLD,
      OP_STORE
   } mac_op_e;

   // One command wins per cycle; everything is dropped while the repeat runs.
   function automatic mac_op_e pick_op(input logic busy, input logic clr,
                                       input logic rpt, input logic fold,
                                       input logic st);
      if (busy)      return OP_NONE;
      else if (clr)  return OP_CLEAR;
      else if (rpt)  return OP_REPEAT;
      else if (fold) return OP_FOLD;
      else if (st)   return OP_STORE;
      else           return OP_NONE;
   endfunction

endpackage

// File: rtl/frac_mac_seq.sv
module frac_mac_seq #(
   parameter int AW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] rpt_count,
   input  logic [AW-1:0] coef_base,
   input  logic [AW-1:0] samp_base,
   output logic          busy,
   output logic [AW-1:0] coef_addr,
   output logic [AW-1:0] samp_addr
);

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] cptr_q;
   logic [AW-1:0] sptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         cptr_q <= '0;
         sptr_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= rpt_count;
         cptr_q <= coef_base;
         sptr_q <= samp_base;
      end else if (busy_q) begin
         cptr_q <= cptr_q + AW'(1);
         sptr_q <= sptr_q + AW'(1);
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - CW'(1);
      end
   end

   assign busy      = busy_q;
   assign coef_addr = cptr_q;
   assign samp_addr = sptr_q;

   // R3: the last step ends the run, earlier steps keep it going
   assert_last_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == '0 && !start) |=> !busy_q);
   assert_keep_going_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q);
   // R4: the first busy cycle presents the captured bases
   assert_addr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (cptr_q == $past(coef_base) && sptr_q == $past(samp_base)));

endmodule

// File: rtl/frac_mac_dp.sv
module frac_mac_dp #(
   parameter int DW    = 16,
   parameter int GUARD = 8,
   localparam int PW   = 2 * DW,
   localparam int ACCW = PW + GUARD
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            step,
   input  logic            fold,
   input  logic [DW-1:0]   coef,
   input  logic [DW-1:0]   samp,
   output logic [ACCW-1:0] acc
);

   logic signed [PW-1:0]   mult;
   logic signed [PW-1:0]   prod_q;
   logic signed [ACCW-1:0] prod_wide;
   logic signed [ACCW-1:0] prod_al;
   logic signed [ACCW-1:0] acc_q;

   assign mult      = PW'($signed(coef)) * PW'($signed(samp));
   assign prod_wide = {{GUARD{prod_q[PW-1]}}, prod_q};
   // drop the doubled sign so the product sits on the accumulator's binary point
   assign prod_al   = {prod_wide[ACCW-2:0], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         acc_q  <= '0;
      end else if (clear) begin
         prod_q <= '0;
         acc_q  <= '0;
      end else if (step) begin
         prod_q <= mult;
         acc_q  <= acc_q + prod_al;
      end else if (fold) begin
         acc_q  <= acc_q + prod_al;
      end
   end

   assign acc = acc_q;

   // R2: clear empties both registers
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (acc_q == '0 && prod_q == '0));
   // R10: with no accepted command the accumulator holds
   assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !step && !fold) |=> $stable(acc_q));
   // R6: folding leaves the product register untouched
   assert_fold_keeps_prod_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fold && !clear && !step) |=> $stable(prod_q));

endmodule

// File: rtl/frac_mac_store.sv
module frac_mac_store #(
   parameter int DW     = 16,
   parameter int GUARD  = 8,
   parameter bit SAT_EN = 1'b1,
   localparam int PW    = 2 * DW,
   localparam int ACCW  = PW + GUARD
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [ACCW-1:0] acc,
   output logic            st_valid,
   output logic [DW-1:0]   st_data
);

   logic [DW-1:0] word;
   logic [DW-1:0] hi;

   assign hi = acc[PW-1:DW];

   generate
      if (SAT_EN) begin : g_sat
         logic [GUARD:0] hdr;
         logic           ovf;
         assign hdr  = acc[ACCW-1:PW-1];
         assign ovf  = !((&hdr) || !(|hdr));
         assign word = !ovf ? hi :
                       acc[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};

         // R8: a clipped word carries the sign of the accumulator
         assert_sat_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en && ovf) |=> (st_data[DW-1] == $past(acc[ACCW-1])));
      end else begin : g_trunc
         assign word = hi;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_valid <= 1'b0;
         st_data  <= '0;
      end else begin
         st_valid <= en;
         if (en) st_data <= word;
      end
   end

endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit #(
   parameter int DW     = 16,
   parameter int GUARD  = 8,
   parameter int AW     = 8,
   parameter int CW     = 8,
   parameter bit SAT_EN = 1'b1,
   localparam int ACC_W = 2 * DW + GUARD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_clear,
   input  logic             cmd_repeat,
   input  logic             cmd_fold,
   input  logic             cmd_store,
   input  logic [CW-1:0]    rpt_count,
   input  logic [AW-1:0]    coef_base,
   input  logic [AW-1:0]    samp_base,
   output logic [AW-1:0]    coef_addr,
   input  logic [DW-1:0]    coef_data,
   output logic [AW-1:0]    samp_addr,
   input  logic [DW-1:0]    samp_data,
   output logic             busy,
   output logic [ACC_W-1:0] acc_out,
   output logic             st_valid,
   output logic [DW-1:0]    st_data
);
   import frac_mac_pkg::*;

   initial begin
      assert (DW >= 2)    else $error("operand width must be at least 2");
      assert (GUARD >= 1) else $error("at least one guard bit is needed");
      assert (AW >= 1)    else $error("address width must be positive");
      assert (CW >= 1)    else $error("count width must be positive");
   end

   mac_op_e op;
   logic    go_clear, go_repeat, go_fold, go_store;

   assign op        = pick_op(busy, cmd_clear, cmd_repeat, cmd_fold, cmd_store);
   assign go_clear  = (op == OP_CLEAR);
   assign go_repeat = (op == OP_REPEAT);
   assign go_fold   = (op == OP_FOLD);
   assign go_store  = (op == OP_STORE);

   frac_mac_seq #(.AW(AW), .CW(CW)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (go_repeat),
      .rpt_count (rpt_count),
      .coef_base (coef_base),
      .samp_base (samp_base),
      .busy      (busy),
      .coef_addr (coef_addr),
      .samp_addr (samp_addr)
   );

   frac_mac_dp #(.DW(DW), .GUARD(GUARD)) dp_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (go_clear),
      .step  (busy),
      .fold  (go_fold),
      .coef  (coef_data),
      .samp  (samp_data),
      .acc   (acc_out)
   );

   frac_mac_store #(.DW(DW), .GUARD(GUARD), .SAT_EN(SAT_EN)) st_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (go_store),
      .acc      (acc_out),
      .st_valid (st_valid),
      .st_data  (st_data)
   );

   // R10/R7: a strobe only follows a store request seen while idle
   assert_store_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> $past(cmd_store && !busy));
   // R7: the strobe lasts a single cycle unless a new store was accepted
   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !go_store) |=> !st_valid);
   // R11: clear beats every other command
   assert_clear_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clear && !busy) |=> (acc_out == '0 && !busy && !st_valid));

endmodule

// File: tb/frac_mac_unit_tb_top.sv
module frac_mac_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 4, GUARD = 4, AW = 4, CW = 4;
   localparam int ACC_W = 2 * DW + GUARD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_clear = 1'b0, cmd_repeat = 1'b0, cmd_fold = 1'b0, cmd_store = 1'b0;
   logic [CW-1:0] rpt_count = '0;
   logic [AW-1:0] coef_base = '0, samp_base = '0;
   logic [AW-1:0] coef_addr, samp_addr;
   logic [DW-1:0] coef_data, samp_data;
   logic busy, st_valid;
   logic [ACC_W-1:0] acc_out;
   logic [DW-1:0] st_data;

   logic [DW-1:0] cmem [16];
   logic [DW-1:0] smem [16];
   int cval [16];
   int sval [16];
   int m_acc, m_prod;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign coef_data = cmem[coef_addr];
   assign samp_data = smem[samp_addr];

   frac_mac_unit #(.DW(DW), .GUARD(GUARD), .AW(AW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .cmd_repeat(cmd_repeat),
      .cmd_fold(cmd_fold), .cmd_store(cmd_store), .rpt_count(rpt_count),
      .coef_base(coef_base), .samp_base(samp_base), .coef_addr(coef_addr),
      .coef_data(coef_data), .samp_addr(samp_addr), .samp_data(samp_data),
      .busy(busy), .acc_out(acc_out), .st_valid(st_valid), .st_data(st_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int acc_now();
      return int'($signed(acc_out));
   endfunction

   function automatic int sat_hi(input int a);
      if (a > 127)  return 7;
      if (a < -128) return -8;
      return a >>> 4;
   endfunction

   task automatic load_mem();
      for (int i = 0; i < 16; i++) begin
         cmem[i] = cval[i][3:0];
         smem[i] = sval[i][3:0];
      end
   endtask

   task automatic pulse(input bit c, input bit r, input bit f, input bit s);
      @(negedge clk);
      cmd_clear = c; cmd_repeat = r; cmd_fold = f; cmd_store = s;
      @(negedge clk);
      cmd_clear = 0; cmd_repeat = 0; cmd_fold = 0; cmd_store = 0;
   endtask

   task automatic do_clear();
      pulse(1, 0, 0, 0);
      m_acc = 0; m_prod = 0;
      chk("R2 clear", acc_now(), 0);
   endtask

   task automatic do_fold(input string req);
      pulse(0, 0, 1, 0);
      m_acc += 2 * m_prod;
      chk(req, acc_now(), m_acc);
   endtask

   task automatic do_store();
      pulse(0, 0, 0, 1);
      chk("R7 strobe high", int'(st_valid), 1);
      if (m_acc > 127 || m_acc < -128)
         chk("R8 saturated word", int'($signed(st_data)), sat_hi(m_acc));
      else
         chk("R7 stored word", int'($signed(st_data)), sat_hi(m_acc));
      @(negedge clk);
      chk("R7 strobe one cycle", int'(st_valid), 0);
   endtask

   // runs a repeat, optionally firing every command mid-run (R10)
   task automatic run_rep(input int n, input int cb, input int sb, input bit inject);
      int cyc = 0;
      rpt_count = n[CW-1:0]; coef_base = cb[AW-1:0]; samp_base = sb[AW-1:0];
      pulse(0, 1, 0, 0);
      while (busy === 1'b1 && cyc < 40) begin
         chk("R4 coef address", int'(coef_addr), (cb + cyc) % 16);
         chk("R4 sample address", int'(samp_addr), (sb + cyc) % 16);
         chk("R10 no strobe while busy", int'(st_valid), 0);
         if (inject && cyc == 1) begin
            cmd_clear = 1; cmd_repeat = 1; cmd_fold = 1; cmd_store = 1;
         end else begin
            cmd_clear = 0; cmd_repeat = 0; cmd_fold = 0; cmd_store = 0;
         end
         cyc++;
         @(negedge clk);
      end
      cmd_clear = 0; cmd_repeat = 0; cmd_fold = 0; cmd_store = 0;
      chk("R3 busy length", cyc, n + 1);
      for (int k = 0; k <= n; k++) begin
         m_acc += 2 * m_prod;
         m_prod = cval[(cb + k) % 16] * sval[(sb + k) % 16];
      end
      chk(inject ? "R10 result after ignored commands" : "R5 lagging sum", acc_now(), m_acc);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin cval[i] = 0; sval[i] = 0; end
      load_mem();
      repeat (3) @(negedge clk);
      chk("R12 reset acc", acc_now(), 0);
      chk("R12 reset busy", int'(busy), 0);
      chk("R12 reset strobe", int'(st_valid), 0);
      chk("R12 reset word", int'(st_data), 0);
      chk("R12 reset coef address", int'(coef_addr), 0);
      chk("R12 reset sample address", int'(samp_addr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // every operand pair through one term and two folds
      for (int a = -8; a < 8; a++) begin
         for (int b = -8; b < 8; b++) begin
            cval[0] = a; sval[0] = b; load_mem();
            do_clear();
            run_rep(0, 0, 0, 0);
            do_fold("R1 aligned product");
            do_store();
            do_fold("R6 second fold repeats product");
            do_store();
         end
      end

      // multi-term runs crossing the top of the address space
      for (int n = 0; n < 8; n++) begin
         for (int i = 0; i < 16; i++) begin
            cval[i] = ((i * 5 + 3) % 16) - 8;
            sval[i] = ((i * 3 + n) % 16) - 8;
         end
         load_mem();
         do_clear();
         run_rep(n, 13, 10, 0);
         do_fold("R6 fold completes sum");
         do_store();
      end

      // commands while busy are dropped
      do_clear();
      run_rep(5, 2, 7, 1);
      do_fold("R10 fold after ignored commands");
      do_store();

      // guard bits: go beyond +1, then come back
      for (int i = 0; i < 4; i++) begin cval[i] = 7; sval[i] = 7; end
      for (int i = 4; i < 8; i++) begin cval[i] = -7; sval[i] = 7; end
      load_mem();
      do_clear();
      run_rep(3, 0, 0, 0);
      do_fold("R9 sum beyond one kept");
      do_store();
      run_rep(3, 4, 4, 0);
      do_fold("R9 sum back in range");
      chk("R9 exact recovered sum", acc_now(), 98);
      do_store();

      // priority among simultaneous commands
      cval[0] = 3; sval[0] = 5; load_mem();
      do_clear();
      run_rep(0, 0, 0, 0);
      pulse(0, 0, 1, 1);
      m_acc += 2 * m_prod;
      chk("R11 fold beats store acc", acc_now(), m_acc);
      chk("R11 fold beats store strobe", int'(st_valid), 0);
      rpt_count = '0; coef_base = '0; samp_base = '0;
      pulse(0, 1, 1, 0);
      chk("R11 repeat beats fold busy", int'(busy), 1);
      chk("R11 repeat beats fold acc", acc_now(), m_acc);
      @(negedge clk);
      m_acc += 2 * m_prod; m_prod = 15;
      chk("R11 repeat step result", acc_now(), m_acc);
      pulse(1, 1, 1, 1);
      m_acc = 0; m_prod = 0;
      chk("R11 clear wins acc", acc_now(), 0);
      chk("R11 clear wins busy", int'(busy), 0);
      chk("R11 clear wins strobe", int'(st_valid), 0);
      do_fold("R2 product cleared too");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule